// File: doc/BRIEF.md
# Load Data Retry Forwarding Stage

This stage sits between an external split-transaction bus and a processor's internal load path. Each read data beat is captured in the cycle where the transfer-acknowledge input is high. The beat is then passed inward as a single-cycle valid strobe together with its data word.

The memory side may cancel a beat by raising the data-retry input in the bus cycle right after that beat's acknowledge. To allow this, in retry-enabled mode the stage keeps each beat for one more cycle before it decides. If retry stays low in that cycle, the beat is forwarded. If retry is high, the beat is dropped, and the memory is expected to send the data again with a later acknowledge. Two registers in series let a new beat be captured while the previous one is still being checked.

A static mode input selects no-retry operation. It is sampled only while reset is held. In no-retry mode the retry input is ignored, and each beat reaches the internal side one cycle earlier than in retry-enabled mode.

Top module: `load_retry_fwd`

## Requirements
- R1: While reset is low at a clock edge, `fwd_valid` is 0 after that edge.
- R2: In no-retry mode, a beat whose `bus_ack` is 1 in cycle N appears with `fwd_valid`=1 and `fwd_data` equal to that cycle's `bus_data` directly after the edge that ends cycle N.
- R3: In retry-enabled mode, a beat acknowledged in cycle N is not forwarded after the edge ending cycle N. If `bus_retry` is 0 in cycle N+1, the beat is forwarded with its captured data after the edge ending cycle N+1.
- R4: In retry-enabled mode, `bus_retry`=1 in cycle N+1 cancels the beat acknowledged in cycle N, and no valid strobe is produced for it. A beat resupplied on a later acknowledge is forwarded normally.
- R5: In no-retry mode, `bus_retry` has no effect on any beat, whether it is raised together with an acknowledge or in the cycle after one.
- R6: In retry-enabled mode, acknowledges in consecutive cycles are all captured. Each beat is forwarded or cancelled on its own, in arrival order, according to the retry level in the cycle after its own acknowledge.
- R7: In retry-enabled mode, `bus_retry` raised in a cycle that does not follow an acknowledge produces no strobe and does not affect later beats.
- R8: `mode_no_retry` (1 = no-retry mode, 0 = retry-enabled) is taken only while `rst_n` is low. Changing it after reset leaves the operating mode unchanged.
- R9: `fwd_valid` is high for exactly one cycle for each accepted beat.
- R10: `bus_data` presented without `bus_ack` produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| mode_no_retry | input | 1 | 1 selects no-retry mode, 0 selects retry-enabled mode |
| bus_ack | input | 1 | Transfer acknowledge for a read data beat |
| bus_retry | input | 1 | Late cancel for the beat acknowledged in the previous cycle |
| bus_data | input | DATA_W | Read data from the bus |
| fwd_valid | output | 1 | One-cycle strobe for a forwarded beat |
| fwd_data | output | DATA_W | Forwarded beat data |

## Verification
The main path is exercised with four patterns:
- a single isolated beat in each mode, which shows the one-cycle latency difference between the modes;
- a beat followed by retry, which separates cancellation from forwarding;
- acknowledges in consecutive cycles with retry on the middle beat, which shows whether the capture and validation registers stay independent and keep order;
- retry with no beat under check, and retry in no-retry mode, which shows that stray or disabled retries have no effect.

Toggling the mode input after reset, followed by another reset, confirms that the mode is sampled only during reset.

// File: rtl/lrf_pkg.sv
// Package: shared types for the load retry forwarding stage.
// Assumes: nothing beyond IEEE 1800-2017.
package lrf_pkg;
    // Operating mode latched at reset.
    typedef enum logic {
        MODE_RETRY   = 1'b0,
        MODE_NORETRY = 1'b1
    } fwd_mode_e;
endpackage

// File: rtl/lrf_mode_latch.sv
// Module: lrf_mode_latch
// Latches the operating mode while reset is held and keeps it afterwards.
// Assumes: the mode input is stable for the last reset cycle.
module lrf_mode_latch
    import lrf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_in,
    output fwd_mode_e mode_q
);
    // Sample the mode only during reset; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_in ? MODE_NORETRY : MODE_RETRY;
        end
    end
endmodule

// File: rtl/lrf_capture.sv
// Module: lrf_capture
// First pipeline entry: captures an acknowledged beat so it can be checked
// against retry in the next cycle. It is active only in retry-enabled mode.
// Assumes: one beat at most per cycle.
module lrf_capture #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ack,
    input  logic [DATA_W-1:0] data_in,
    output logic              held_vld,
    output logic [DATA_W-1:0] held_data
);
    // Flag a beat as under check for exactly the cycle after its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld <= 1'b0;
        end else begin
            held_vld <= enable && ack;
        end
    end

    // Keep the data of the newest acknowledged beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data <= '0;
        end else if (enable && ack) begin
            held_data <= data_in;
        end
    end
endmodule

// File: rtl/lrf_forward.sv
// Module: lrf_forward
// Second pipeline entry: registered output strobe and data. In no-retry mode
// it takes the bus beat directly. In retry-enabled mode it takes the held
// beat when no retry is seen in the checking cycle.
// Assumes: the mode is constant outside reset.
module lrf_forward #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              ack,
    input  logic              retry,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              held_vld,
    input  logic [DATA_W-1:0] held_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic              take;
    logic [DATA_W-1:0] take_data;

    // Select the beat source for this cycle; retry matters only in held mode.
    always_comb begin
        if (bypass) begin
            take      = ack;
            take_data = bus_data;
        end else begin
            take      = held_vld && !retry;
            take_data = held_data;
        end
    end

    // Register the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= take;
        end
    end

    // Register the data only when a beat is forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (take) begin
            out_data <= take_data;
        end
    end
endmodule

// File: rtl/load_retry_fwd.sv
// Module: load_retry_fwd (top)
// Forwards read beats from the bus to the internal load path. In retry-enabled
// mode each beat is checked for one cycle against a late retry. In no-retry
// mode beats go straight to the output register.
// Assumes: synchronous active-low reset; the mode is held stable during reset;
// the system does not rely on retry in no-retry mode.
module load_retry_fwd
    import lrf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_no_retry,
    input  logic              bus_ack,
    input  logic              bus_retry,
    input  logic [DATA_W-1:0] bus_data,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data
);
    fwd_mode_e         mode_q;
    logic              bypass_q;
    logic              held_vld;
    logic [DATA_W-1:0] held_data;

    // Decode the latched mode into the bypass select.
    assign bypass_q = (mode_q == MODE_NORETRY);

    lrf_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_no_retry),
        .mode_q  (mode_q)
    );

    lrf_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!bypass_q),
        .ack       (bus_ack),
        .data_in   (bus_data),
        .held_vld  (held_vld),
        .held_data (held_data)
    );

    lrf_forward #(.DATA_W(DATA_W)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (bypass_q),
        .ack       (bus_ack),
        .retry     (bus_retry),
        .bus_data  (bus_data),
        .held_vld  (held_vld),
        .held_data (held_data),
        .out_vld   (fwd_valid),
        .out_data  (fwd_data)
    );
endmodule

// File: rtl/load_retry_fwd_chk.sv
// Module: load_retry_fwd_chk
// Temporal checks on the forwarding stage, bound into the top module.
module load_retry_fwd_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bypass_q,
    input logic              bus_ack,
    input logic              bus_retry,
    input logic [DATA_W-1:0] bus_data,
    input logic              fwd_valid,
    input logic [DATA_W-1:0] fwd_data
);
    // R1: reset clears the strobe.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !fwd_valid);

    // R2: a no-retry beat is forwarded at the next edge with its data.
    p_direct_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_q && bus_ack) |=> (fwd_valid && fwd_data == $past(bus_data)));

    // R3: a retry-mode beat without retry is forwarded one cycle later.
    p_held_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_q && bus_ack) ##1 !bus_retry |=>
            (fwd_valid && fwd_data == $past(bus_data, 2)));

    // R4: retry in the cycle after an acknowledge cancels that beat.
    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_q && bus_ack) ##1 bus_retry |=> !fwd_valid);

    // R10: in no-retry mode, no acknowledge means no strobe.
    p_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_q && !bus_ack) |=> !fwd_valid);

    // R8: the operating mode does not move outside reset.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(bypass_q));
endmodule

bind load_retry_fwd load_retry_fwd_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass_q  (bypass_q),
    .bus_ack   (bus_ack),
    .bus_retry (bus_retry),
    .bus_data  (bus_data),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data)
);

// File: tb/load_retry_fwd_tb_top.sv
`timescale 1ns/100ps
module load_retry_fwd_tb_top;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_no_retry = 1'b0;
    logic              bus_ack = 1'b0;
    logic              bus_retry = 1'b0;
    logic [DATA_W-1:0] bus_data = '0;
    logic              fwd_valid;
    logic [DATA_W-1:0] fwd_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    load_retry_fwd #(.DATA_W(DATA_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_no_retry (mode_no_retry),
        .bus_ack       (bus_ack),
        .bus_retry     (bus_retry),
        .bus_data      (bus_data),
        .fwd_valid     (fwd_valid),
        .fwd_data      (fwd_data)
    );

    // Drive one cycle of inputs, then sample just after the ending edge.
    task automatic cyc(input logic a, input logic r, input logic [DATA_W-1:0] d);
        bus_ack   = a;
        bus_retry = r;
        bus_data  = d;
        @(posedge clk);
        #1;
    endtask

    // Compare the strobe, and the data when a beat is expected.
    task automatic expect_out(input string tag, input logic v, input logic [DATA_W-1:0] d);
        n_tests++;
        if (fwd_valid !== v || (v && fwd_data !== d)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, fwd_valid, fwd_data, v, d);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        mode_no_retry = mode;
        cyc(1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, '0);
        expect_out("R1 reset", 1'b0, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_direct;
        do_reset(1'b1);
        cyc(1'b1, 1'b0, 32'hA0A0_0001); expect_out("R2 direct beat", 1'b1, 32'hA0A0_0001);
        cyc(1'b0, 1'b0, 32'hDEAD_BEEF); expect_out("R9/R10 single pulse", 1'b0, '0);
    endtask

    task automatic t_retry_ignored;
        do_reset(1'b1);
        cyc(1'b1, 1'b0, 32'hB000_0001); expect_out("R5 first beat", 1'b1, 32'hB000_0001);
        cyc(1'b1, 1'b1, 32'hB000_0002); expect_out("R5 retry ignored", 1'b1, 32'hB000_0002);
        cyc(1'b0, 1'b1, 32'h0);         expect_out("R5 no strobe", 1'b0, '0);
    endtask

    task automatic t_held;
        do_reset(1'b0);
        cyc(1'b1, 1'b0, 32'hC000_0001); expect_out("R3 not yet", 1'b0, '0);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R3 held beat", 1'b1, 32'hC000_0001);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R9 pulse ends", 1'b0, '0);
    endtask

    task automatic t_cancel;
        do_reset(1'b0);
        cyc(1'b1, 1'b0, 32'hD000_0001);
        cyc(1'b0, 1'b1, 32'h0);         expect_out("R4 cancelled", 1'b0, '0);
        cyc(1'b1, 1'b0, 32'hD000_0002); expect_out("R4 wait", 1'b0, '0);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R4 resupply", 1'b1, 32'hD000_0002);
    endtask

    task automatic t_back_to_back;
        do_reset(1'b0);
        cyc(1'b1, 1'b0, 32'hE000_0001);
        cyc(1'b1, 1'b0, 32'hE000_0002); expect_out("R6 first", 1'b1, 32'hE000_0001);
        cyc(1'b1, 1'b1, 32'hE000_0003); expect_out("R6 second cancelled", 1'b0, '0);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R6 third", 1'b1, 32'hE000_0003);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R6 idle", 1'b0, '0);
    endtask

    task automatic t_stray_retry;
        do_reset(1'b0);
        cyc(1'b0, 1'b1, 32'hF000_0001); expect_out("R7 stray retry", 1'b0, '0);
        cyc(1'b0, 1'b1, 32'hF000_0002); expect_out("R10 data no ack", 1'b0, '0);
        cyc(1'b1, 1'b0, 32'hF000_0003);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R7 later beat intact", 1'b1, 32'hF000_0003);
    endtask

    task automatic t_mode_lock;
        do_reset(1'b0);
        mode_no_retry = 1'b1;
        cyc(1'b1, 1'b0, 32'h1234_0001); expect_out("R8 still held mode", 1'b0, '0);
        cyc(1'b0, 1'b0, 32'h0);         expect_out("R8 held forward", 1'b1, 32'h1234_0001);
        do_reset(1'b1);
        mode_no_retry = 1'b0;
        cyc(1'b1, 1'b0, 32'h1234_0002); expect_out("R8 still direct", 1'b1, 32'h1234_0002);
    endtask

    initial begin
        t_direct();
        t_retry_ignored();
        t_held();
        t_cancel();
        t_back_to_back();
        t_stray_retry();
        t_mode_lock();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule